// File: doc/BRIEF.md
# Multichannel ADC Conversion Sequencer

The sequencer runs one conversion at a time on an external eight-input, 8-bit successive-approximation converter. That converter has separate start, end-of-conversion and output-enable pins. A host asks for a conversion by raising a request together with a 3-bit channel number. The sequencer first puts the channel address on the converter's address pins and strobes the address latch. It then puts the external sample-and-hold into hold and gives a low-high-low start pulse. After that it waits for end-of-conversion, turns on the converter's output latch and captures the byte. The result comes back to the host with a one-cycle done pulse.

End-of-conversion arrives from another clock domain, so it passes through a synchronizer. Completion needs a low-then-high sequence on that signal after the start pulse. A level left high from an earlier conversion is therefore never taken as a finished conversion. A converter that never finishes is cut off by a timeout. The timeout returns the block to idle, releases hold and output-enable, and pulses an error flag. The last good result and its channel stay visible until a later conversion completes.

Top module: `adc_seq`

## Requirements
- R1: A request is taken only while `busy_o` is low. `busy_o` goes high in the cycle after the request is taken and stays high until the cycle in which `done_o` or `err_o` pulses. A request raised while busy has no effect on the conversion in flight or on its reported channel.
- R2: From the cycle after acceptance, `adc_addr_o` carries the requested channel in plain binary, with bit 2 as the most significant address line, so 3'b010 selects input 2. The address stays stable for the whole conversion. `adc_ale_o` pulses for exactly one cycle with that address present, and the pulse comes before the start pulse.
- R3: The start line is low for one cycle with hold already asserted. It is then high for exactly `SOC_HIGH_CYC` cycles (at least 2) and then low again.
- R4: `adc_hold_o` is high from the cycle before the start pulse rises and stays high without a break until synchronized end-of-conversion has been seen high. It is low in every cycle in which `adc_oe_o` is high.
- R5: End-of-conversion passes through a two-flop synchronizer. A conversion completes only after the synchronized level has been seen low following the start pulse and then high. A level that stays high throughout never completes a conversion.
- R6: `adc_oe_o` is high for exactly two cycles after completion is detected. The data byte is captured in the second of those cycles, with bit 7 as the most significant bit.
- R7: `done_o` pulses for one cycle. In that cycle `result_o` and `result_ch_o` hold the captured byte and its channel, and they keep these values until the next conversion completes. A timed-out conversion leaves them unchanged.
- R8: If a conversion has not completed `TIMEOUT_CYC` cycles after the first cycle of the start pulse, `err_o` pulses for one cycle exactly `TIMEOUT_CYC` cycles after that first cycle. At that point the block is idle, with hold, start and output-enable low.
- R9: Out of reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Host conversion request |
| ch_i | input | 3 | Requested channel |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle timeout pulse |
| result_o | output | 8 | Last captured byte |
| result_ch_o | output | 3 | Channel of the last captured byte |
| adc_addr_o | output | 3 | Converter channel address |
| adc_ale_o | output | 1 | Converter address latch strobe |
| adc_hold_o | output | 1 | Sample-and-hold control, high to hold |
| adc_soc_o | output | 1 | Start-of-conversion pulse |
| adc_eoc_i | input | 1 | End-of-conversion from the converter |
| adc_oe_o | output | 1 | Converter output-latch enable |
| adc_data_i | input | 8 | Converter output data |

## Verification
The bench's converter model drives a byte only while output-enable is high, and the bench gives each channel a different byte with the top bit set on some of them. A block that captured the data too early would therefore read zero, and a block with a swapped channel would report the wrong byte. One converter mode leaves end-of-conversion high throughout: a block that skipped the low phase would report done at once instead of timing out. Another mode never raises end-of-conversion, and the bench checks the exact cycle of the error pulse and that the earlier result survives. The bench also raises a request while busy, which would change the reported channel if it were wrongly accepted. The start-pulse width, the single address strobe and an unbroken hold interval are measured on every conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_LATCH,
    S_HOLD,
    S_START,
    S_WAIT_LO,
    S_WAIT_HI,
    S_READ,
    S_CAP
  } seq_state_e;

  // Bits needed to count from 0 up to limit-1.
  function automatic int unsigned cnt_bits(int unsigned limit);
    return (limit < 3) ? 1 : $clog2(limit);
  endfunction

  // States in which the timeout window runs.
  function automatic logic in_conversion(seq_state_e s);
    return (s == S_START) || (s == S_WAIT_LO) || (s == S_WAIT_HI);
  endfunction

  // States in which the analog input must be frozen.
  function automatic logic holds_input(seq_state_e s);
    return (s == S_HOLD) || in_conversion(s);
  endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
  import adc_seq_pkg::*;
#(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic hit_o
);
  localparam int unsigned W = cnt_bits(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned NUM_CH       = 8,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned SOC_HIGH_CYC = 4,
  parameter int unsigned TIMEOUT_CYC  = 100000,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_i,
  input  logic [$clog2(NUM_CH)-1:0]  ch_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       err_o,
  output logic [DATA_W-1:0]          result_o,
  output logic [$clog2(NUM_CH)-1:0]  result_ch_o,
  output logic [$clog2(NUM_CH)-1:0]  adc_addr_o,
  output logic                       adc_ale_o,
  output logic                       adc_hold_o,
  output logic                       adc_soc_o,
  input  logic                       adc_eoc_i,
  output logic                       adc_oe_o,
  input  logic [DATA_W-1:0]          adc_data_i
);
  localparam int unsigned CH_W = $clog2(NUM_CH);

  seq_state_e        state_q, state_d;
  logic [CH_W-1:0]   addr_q;
  logic [CH_W-1:0]   res_ch_q;
  logic [DATA_W-1:0] result_q;
  logic              done_q, err_q;

  // Named internal events
  logic eoc_s;
  logic soc_hit;
  logic tmo_hit;
  logic accept;
  logic eoc_seen_hi;
  logic abort;
  logic capture;

  adc_seq_sync #(.STAGES(SYNC_STAGES)) u_eoc_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (adc_eoc_i),
    .sync_o  (eoc_s)
  );

  adc_seq_timer #(.LIMIT(SOC_HIGH_CYC)) u_soc_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (state_q == S_START),
    .hit_o (soc_hit)
  );

  adc_seq_timer #(.LIMIT(TIMEOUT_CYC)) u_tmo_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (in_conversion(state_q)),
    .hit_o (tmo_hit)
  );

  assign accept      = (state_q == S_IDLE) && req_i;
  assign eoc_seen_hi = (state_q == S_WAIT_HI) && eoc_s;
  assign abort       = tmo_hit && !eoc_seen_hi;
  assign capture     = (state_q == S_CAP);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (accept) state_d = S_ADDR;
      S_ADDR:    state_d = S_LATCH;
      S_LATCH:   state_d = S_HOLD;
      S_HOLD:    state_d = S_START;
      S_START:   if (soc_hit) state_d = S_WAIT_LO;
      S_WAIT_LO: if (!eoc_s) state_d = S_WAIT_HI;
      S_WAIT_HI: if (eoc_s) state_d = S_READ;
      S_READ:    state_d = S_CAP;
      S_CAP:     state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
    if (abort) state_d = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      addr_q   <= '0;
      res_ch_q <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= capture;
      err_q   <= abort;
      if (accept) addr_q <= ch_i;
      if (capture) begin
        result_q <= adc_data_i;
        res_ch_q <= addr_q;
      end
    end
  end

  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign result_o    = result_q;
  assign result_ch_o = res_ch_q;
  assign adc_addr_o  = addr_q;
  assign adc_ale_o   = (state_q == S_LATCH);
  assign adc_hold_o  = holds_input(state_q);
  assign adc_soc_o   = (state_q == S_START);
  assign adc_oe_o    = (state_q == S_READ) || capture;

  // ---------------- assertions ----------------
  assert_addr_stable_in_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_hold_o |-> $stable(adc_addr_o));

  assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_ale_o |=> !adc_ale_o);

  assert_soc_rise_after_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_soc_o) |-> $past(adc_hold_o));

  assert_soc_min_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_soc_o) |-> $past(adc_soc_o, 2));

  assert_soc_needs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_soc_o |-> adc_hold_o);

  assert_hold_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_hold_o) |-> (adc_oe_o || err_o));

  assert_no_hold_with_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_oe_o |-> !adc_hold_o);

  assert_capture_after_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(adc_oe_o));

  assert_done_err_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  assert_idle_on_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!busy_o && !adc_hold_o && !adc_oe_o && !adc_soc_o));

  assert_idle_on_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

// File: tb/adc_seq_tb.sv
module adc_seq_tb;
  localparam int SOCW = 3;
  localparam int TMO  = 40;
  localparam int CONV = 10;
  localparam int WDOG = 20000;

  localparam int M_NORMAL = 0;
  localparam int M_STUCK  = 1;
  localparam int M_NEVER  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_i = 1'b0;
  logic [2:0] ch_i = '0;
  logic       busy_o, done_o, err_o;
  logic [7:0] result_o;
  logic [2:0] result_ch_o, adc_addr_o;
  logic       adc_ale_o, adc_hold_o, adc_soc_o, adc_oe_o;
  logic       adc_eoc_i;
  logic [7:0] adc_data_i;

  always #2.5 clk = ~clk;

  adc_seq #(
    .NUM_CH(8), .DATA_W(8), .SOC_HIGH_CYC(SOCW), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ch_i(ch_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .result_o(result_o), .result_ch_o(result_ch_o),
    .adc_addr_o(adc_addr_o), .adc_ale_o(adc_ale_o), .adc_hold_o(adc_hold_o),
    .adc_soc_o(adc_soc_o), .adc_eoc_i(adc_eoc_i), .adc_oe_o(adc_oe_o),
    .adc_data_i(adc_data_i)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] model_val(input logic [2:0] c);
    return 8'h81 + 8'(c) * 8'd37;
  endfunction

  // ---------------- converter model ----------------
  int         stub_mode = M_NORMAL;
  logic [2:0] stub_ch = '0;
  logic       stub_eoc = 1'b1;
  logic       stub_prev_soc = 1'b0;
  bit         stub_run = 0;
  int         stub_cnt = 0;

  assign adc_eoc_i  = stub_eoc;
  assign adc_data_i = adc_oe_o ? model_val(stub_ch) : 8'h00;

  always @(negedge clk) begin
    if (adc_ale_o) stub_ch = adc_addr_o;
    if (stub_mode == M_STUCK) begin
      stub_eoc = 1'b1;
      stub_run = 0;
    end else begin
      if (adc_soc_o && !stub_prev_soc) begin
        stub_eoc = 1'b0;
        stub_run = 0;
      end
      if (!adc_soc_o && stub_prev_soc && stub_mode == M_NORMAL) begin
        stub_run = 1;
        stub_cnt = 0;
      end
      if (stub_run) begin
        stub_cnt++;
        if (stub_cnt == CONV) begin
          stub_eoc = 1'b1;
          stub_run = 0;
        end
      end
    end
    stub_prev_soc = adc_soc_o;
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    bit         err;
    logic [2:0] ch;
    logic [7:0] data;
  } exp_t;
  exp_t exp_q[$];

  int   resp_cnt = 0;
  bit   mon_on = 0;
  logic prev_soc_m = 1'b0, prev_hold_m = 1'b0;
  int   soc_run = 0, soc_width = -1;
  bit   soc_pre_ok = 1;
  int   ale_cnt = 0;
  logic [2:0] ale_addr = '0;
  int   oe_cnt = 0;
  bit   in_win = 0, hold_ok = 1, oe_hold_ok = 1;
  bit   counting = 0;
  int   cyc = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (counting) cyc++;
      if (adc_soc_o && !prev_soc_m) begin
        counting = 1;
        cyc = 0;
        in_win = 1;
        if (!prev_hold_m) soc_pre_ok = 0;
        soc_run = 0;
      end
      if (adc_soc_o) soc_run++;
      if (!adc_soc_o && prev_soc_m) soc_width = soc_run;
      if (adc_ale_o) begin
        ale_cnt++;
        ale_addr = adc_addr_o;
      end
      if (adc_oe_o) begin
        oe_cnt++;
        in_win = 0;
        if (adc_hold_o) oe_hold_ok = 0;
      end
      if (in_win && !adc_hold_o) hold_ok = 0;

      if (done_o || err_o) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          check(0, "R7", "unexpected response", 1, 0);
        end else begin
          e = exp_q.pop_front();
          if (!e.err) begin
            check(done_o && !err_o, "R7", "done expected", {done_o, err_o}, 2);
            check(result_o == e.data, "R6", "result byte", result_o, e.data);
            check(result_ch_o == e.ch, "R7", "result channel", result_ch_o, e.ch);
            check(ale_cnt == 1 && ale_addr == e.ch, "R2", "address strobe", {ale_cnt, ale_addr}, {1, e.ch});
            check(soc_width == SOCW && soc_pre_ok, "R3", "start width", soc_width, SOCW);
            check(hold_ok && oe_hold_ok, "R4", "hold interval", {hold_ok, oe_hold_ok}, 3);
            check(oe_cnt == 2, "R6", "oe cycles", oe_cnt, 2);
          end else begin
            check(err_o && !done_o, "R8", "error expected", {done_o, err_o}, 1);
            check(cyc == TMO, "R8", "timeout cycle", cyc, TMO);
            check(!busy_o && !adc_hold_o && !adc_oe_o && !adc_soc_o, "R8", "idle after abort",
                  {busy_o, adc_hold_o, adc_oe_o, adc_soc_o}, 0);
            check(result_o == e.data && result_ch_o == e.ch, "R7", "result kept on timeout",
                  {result_ch_o, result_o}, {e.ch, e.data});
            check(oe_cnt == 0, "R6", "no oe on timeout", oe_cnt, 0);
          end
        end
        ale_cnt = 0; oe_cnt = 0; in_win = 0; hold_ok = 1; oe_hold_ok = 1;
        counting = 0; soc_width = -1; soc_pre_ok = 1;
        resp_cnt++;
      end
      prev_soc_m  = adc_soc_o;
      prev_hold_m = adc_hold_o;
    end
  end

  // ---------------- driver ----------------
  logic [2:0] last_ch = '0;
  logic [7:0] last_data = '0;
  bit         last_was_err = 0;

  always @(negedge clk) if (mon_on && (done_o || err_o)) last_was_err = err_o;

  task automatic do_conv(input logic [2:0] ch, input int mode, input bit poke);
    exp_t e;
    int   base;
    stub_mode = mode;
    while (busy_o) @(negedge clk);
    req_i = 1'b1;
    ch_i  = ch;
    if (mode == M_NORMAL) begin
      e.err = 0; e.ch = ch; e.data = model_val(ch);
      last_ch = ch; last_data = model_val(ch);
    end else begin
      e.err = 1; e.ch = last_ch; e.data = last_data;
    end
    exp_q.push_back(e);
    base = resp_cnt;
    @(negedge clk);
    req_i = 1'b0;
    check(busy_o == 1'b1, "R1", "busy after accept", busy_o, 1);
    check(adc_addr_o == ch, "R2", "address driven", adc_addr_o, ch);
    if (poke) begin
      @(negedge clk);
      req_i = 1'b1;
      ch_i  = ~ch;
      @(negedge clk);
      req_i = 1'b0;
    end
    while (resp_cnt == base) @(negedge clk);
    if (poke)
      check(result_ch_o == ch, "R1", "request while busy ignored", result_ch_o, ch);
    if (mode == M_STUCK)
      check(last_was_err, "R5", "stale high eoc did not complete", last_was_err, 1);
    @(negedge clk);
    check(!done_o && !err_o, "R7", "response is one cycle", {done_o, err_o}, 0);
  endtask

  // ---------------- watchdog ----------------
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check({busy_o, done_o, err_o, result_o, result_ch_o, adc_addr_o, adc_ale_o,
           adc_hold_o, adc_soc_o, adc_oe_o} == '0, "R9", "reset outputs", busy_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1;
    check(!busy_o && !adc_soc_o, "R9", "idle after reset", {busy_o, adc_soc_o}, 0);

    do_conv(3'd2, M_NORMAL, 0);
    do_conv(3'd0, M_NORMAL, 0);
    do_conv(3'd7, M_NORMAL, 1);
    do_conv(3'd5, M_NORMAL, 1);
    do_conv(3'd3, M_STUCK,  0);
    do_conv(3'd6, M_NEVER,  0);
    do_conv(3'd1, M_NORMAL, 0);
    do_conv(3'd4, M_NORMAL, 0);

    check(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule